// File: doc/BRIEF.md
# Multi-Mode Built-In Self-Test Register

This block is a bank of flip-flops that a test controller can switch among four jobs. In functional operation it captures a parallel word on every clock. For scan access it becomes a simple shift chain. During self-test it runs as an internal-form linear feedback shift register. With its parallel inputs ignored it produces pseudo-random patterns. With its parallel inputs folded in, it compacts a stream of response words from a circuit under test into one signature.

The feedback taps come from a coefficient input, so one instance can be given any characteristic polynomial of its width. When a test ends, the controller pulses a check input. The register then compares its current contents with an expected signature and holds the verdict on a result flag until the next check. For a long response stream, a wrong stream ends on the right signature with a probability of roughly 2^-n. A polynomial with at least two nonzero coefficients always exposes a single flipped response bit.

Top module: `bist_mode_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sig_out` is all zeros, and `scan_out`, `pass` and `checked` are 0.
- R2: Mode code 2'b00 (normal). On the next rising edge `sig_out` takes the value of `par_in`.
- R3: Mode code 2'b01 (scan). Each edge moves bit i into bit i+1 and loads `scan_in` into bit 0. No feedback and no `par_in` reaches the state. `scan_out` always equals bit WIDTH-1.
- R4: Mode code 2'b10 (generate). With feedback f = bit WIDTH-1, the next bit 0 is `poly[0]`&f. For i>0 the next bit i is bit i-1 XOR (`poly[i]`&f). `par_in` has no effect. `poly` bit i is the coefficient of x^i, and x^WIDTH is implied. With `poly`=8'h1D and a nonzero seed, the sequence repeats after exactly 255 steps.
- R5: Mode code 2'b11 (compact). The next state is the R4 next state XOR `par_in`, bit for bit.
- R6: Running compact mode with `par_in` all zeros gives the same state sequence as generate mode from the same seed.
- R7: The edge that samples `check` high loads `pass` with (`sig_out` == `golden`) as they were before that edge, and sets `checked`. While `check` is low, both flags hold.
- R8: A single bit flipped in one response word of a compacted stream changes the final signature, so a check against the fault-free signature leaves `pass` at 0.
- R9: A change of `mode` acts at the first rising edge that samples the new code. No extra latency is added.
- R10: In generate mode an all-zero state stays all zero. If `poly[0]` is 1, a nonzero state never becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 normal, 01 scan, 10 generate, 11 compact |
| par_in | input | WIDTH | Parallel data or response word |
| scan_in | input | 1 | Serial input into bit 0 |
| poly | input | WIDTH | Feedback coefficients, bit i is the x^i term |
| golden | input | WIDTH | Expected signature |
| check | input | 1 | Latch the comparison of state with `golden` |
| sig_out | output | WIDTH | Current register contents |
| scan_out | output | 1 | Bit WIDTH-1 of the register |
| pass | output | 1 | Result of the last comparison |
| checked | output | 1 | At least one comparison has been made since reset |

## Verification
The hardest case to reach from the ports is a faulty response stream that still has to be told apart from the good one. Reaching it takes a full compaction run, a seed loaded through normal mode, and a second identical run that differs in a single bit of one word. The bench computes the good signature with its own model and supplies it as `golden`. It then reruns the stream with one bit flipped and requires `pass` to drop. The full 255-step period of the generator is confirmed by counting edges until the seed reappears at `sig_out`.

// File: rtl/bist_mode_pkg.sv
package bist_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_SCAN    = 2'b01,
        MODE_GEN     = 2'b10,
        MODE_COMPACT = 2'b11
    } bmr_mode_e;

endpackage

// File: rtl/bist_mode_cell.sv
module bist_mode_cell
    import bist_mode_pkg::*;
#(
    parameter bit FIRST = 1'b0
) (
    input  bmr_mode_e mode_i,
    input  logic      chain_i,
    input  logic      par_i,
    input  logic      tap_i,
    input  logic      fb_i,
    output logic      d_o
);
    logic lin_in;
    logic fold;

    generate
        if (FIRST) begin : g_head
            assign lin_in = 1'b0;
        end else begin : g_body
            assign lin_in = chain_i;
        end
    endgenerate

    assign fold = lin_in ^ (tap_i & fb_i);

    always_comb begin
        unique case (mode_i)
            MODE_NORMAL:  d_o = par_i;
            MODE_SCAN:    d_o = chain_i;
            MODE_GEN:     d_o = fold;
            MODE_COMPACT: d_o = fold ^ par_i;
            default:      d_o = par_i;
        endcase
    end

endmodule

// File: rtl/bist_mode_judge.sv
module bist_mode_judge #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_i,
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] golden_i,
    output logic             pass_o,
    output logic             checked_o
);
    typedef struct packed {
        logic pass;
        logic checked;
    } judge_t;

    judge_t jd_d, jd_q;
    logic   match;

    assign match = (state_i == golden_i);

    always_comb begin
        jd_d = jd_q;
        if (check_i) begin
            jd_d.pass    = match;
            jd_d.checked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) jd_q <= '0;
        else        jd_q <= jd_d;
    end

    assign pass_o    = jd_q.pass;
    assign checked_o = jd_q.checked;

    AST_PASS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        check_i |=> (pass_o == ($past(state_i) == $past(golden_i))) && checked_o); // R7
    AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !check_i |=> $stable(pass_o) && $stable(checked_o)); // R7
    AST_PASS_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> checked_o); // R7

endmodule

// File: rtl/bist_mode_reg.sv
module bist_mode_reg
    import bist_mode_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] poly,
    input  logic [WIDTH-1:0] golden,
    input  logic             check,
    output logic [WIDTH-1:0] sig_out,
    output logic             scan_out,
    output logic             pass,
    output logic             checked
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sig;
    } reg_t;

    reg_t             rg_d, rg_q;
    bmr_mode_e        mode_e;
    logic             fb;
    logic [WIDTH-1:0] chain;
    logic [WIDTH-1:0] cell_d;

    assign mode_e = bmr_mode_e'(mode);
    assign fb     = rg_q.sig[MSB];

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            if (i == 0) begin : g_src0
                assign chain[i] = scan_in;
            end else begin : g_srcn
                assign chain[i] = rg_q.sig[i-1];
            end
            bist_mode_cell #(.FIRST(i == 0)) u_cell (
                .mode_i  (mode_e),
                .chain_i (chain[i]),
                .par_i   (par_in[i]),
                .tap_i   (poly[i]),
                .fb_i    (fb),
                .d_o     (cell_d[i])
            );
        end
    endgenerate

    always_comb begin
        rg_d     = rg_q;
        rg_d.sig = cell_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign sig_out  = rg_q.sig;
    assign scan_out = rg_q.sig[MSB];

    bist_mode_judge #(.WIDTH(WIDTH)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .check_i   (check),
        .state_i   (rg_q.sig),
        .golden_i  (golden),
        .pass_o    (pass),
        .checked_o (checked)
    );

    AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> sig_out == $past(par_in)); // R2
    AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (sig_out[MSB:1] == $past(sig_out[MSB-1:0])) && (sig_out[0] == $past(scan_in))); // R3
    AST_GEN_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && sig_out == '0) |=> sig_out == '0); // R10
    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && sig_out != '0 && poly[0]) |=> sig_out != '0); // R10
    AST_FB_SHIFT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !scan_out) |=> sig_out[MSB:1] == ($past(sig_out[MSB-1:0]) ^ ($past(par_in[MSB:1]) & {MSB{$past(mode[0])}}))); // R5

endmodule

// File: tb/tb_bist_mode_reg.sv
`timescale 1ns/1ps
module tb_bist_mode_reg;
    localparam int W = 8;
    localparam logic [W-1:0] POLY = 8'h1D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] par_in = '0;
    logic         scan_in = 1'b0;
    logic [W-1:0] poly = POLY;
    logic [W-1:0] golden = '0;
    logic         check = 1'b0;
    logic [W-1:0] sig_out;
    logic         scan_out, pass, checked;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] m;

    always #2 clk = ~clk;

    bist_mode_reg #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in), .scan_in(scan_in),
        .poly(poly), .golden(golden), .check(check), .sig_out(sig_out),
        .scan_out(scan_out), .pass(pass), .checked(checked)
    );

    // vector: mode[10:9], scan_in[8], par_in[7:0]
    localparam logic [10:0] VEC [16] = '{
        {2'b00, 1'b0, 8'hA5}, {2'b01, 1'b1, 8'hFF}, {2'b01, 1'b0, 8'h00}, {2'b01, 1'b1, 8'h3C},
        {2'b10, 1'b0, 8'hFF}, {2'b10, 1'b1, 8'h12}, {2'b10, 1'b0, 8'h00}, {2'b11, 1'b0, 8'h5A},
        {2'b11, 1'b1, 8'h81}, {2'b11, 1'b0, 8'h00}, {2'b00, 1'b0, 8'h80}, {2'b10, 1'b0, 8'h77},
        {2'b11, 1'b0, 8'h01}, {2'b01, 1'b1, 8'hC3}, {2'b10, 1'b0, 8'h00}, {2'b00, 1'b1, 8'h00}
    };

    function automatic logic [W-1:0] mstep(input logic [W-1:0] s, input logic [1:0] md,
                                            input logic [W-1:0] p, input logic si);
        logic [W-1:0] lin;
        lin = {s[W-2:0], 1'b0} ^ (POLY & {W{s[W-1]}});
        case (md)
            2'b00:   return p;
            2'b01:   return {s[W-2:0], si};
            2'b10:   return lin;
            default: return lin ^ p;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] md, input logic [W-1:0] p, input logic si);
        @(negedge clk);
        mode = md; par_in = p; scan_in = si;
        m = mstep(m, md, p, si);
        @(posedge clk); #1;
    endtask

    task automatic load(input logic [W-1:0] v);
        drive(2'b00, v, 1'b0);
    endtask

    task automatic do_check(input logic [W-1:0] g);
        @(negedge clk);
        golden = g; check = 1'b1; mode = 2'b00; par_in = sig_out; m = sig_out;
        @(posedge clk); #1;
        check = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] seq_a [10];
        logic [W-1:0] good_sig, bad_sig, wrd;
        int period;
        m = '0;
        #10;
        // R1 reset state
        chk(sig_out == '0 && !scan_out && !pass && !checked, "R1", sig_out, '0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(sig_out == '0 && !pass && !checked, "R1", {6'b0, pass, checked}, '0);

        // table walk, R2 R3 R4 R5 R9: each new mode code acts at the next edge
        for (int i = 0; i < 16; i++) begin
            drive(VEC[i][10:9], VEC[i][7:0], VEC[i][8]);
            chk(sig_out == m, VEC[i][10:9] == 2'b00 ? "R2/R9" : VEC[i][10:9] == 2'b01 ? "R3/R9" :
                              VEC[i][10:9] == 2'b10 ? "R4/R9" : "R5/R9", sig_out, m);
            chk(scan_out == m[W-1], "R3 scan_out", {7'b0, scan_out}, {7'b0, m[W-1]});
        end

        // R3: scan shifts pattern out serially
        load(8'b1011_0010);
        for (int i = 0; i < W; i++) begin
            logic expb;
            expb = m[W-1];
            chk(scan_out == expb, "R3 serial", {7'b0, scan_out}, {7'b0, expb});
            drive(2'b01, 8'hFF, 1'b0);
        end
        chk(sig_out == '0, "R3 flushed", sig_out, '0);

        // R4 period 255
        load(8'h01);
        period = 0;
        for (int i = 1; i <= 300; i++) begin
            drive(2'b10, 8'hFF, 1'b1);
            if (sig_out == 8'h01 && period == 0) period = i;
        end
        chk(period == 255, "R4 period", period[W-1:0], 8'd255);

        // R10 lockup
        load(8'h00);
        for (int i = 0; i < 5; i++) drive(2'b10, 8'hA5, 1'b1);
        chk(sig_out == '0, "R10 zero stays", sig_out, '0);

        // R6 generate equals compact with zero inputs
        load(8'h6B);
        for (int i = 0; i < 10; i++) begin drive(2'b10, 8'h00, 1'b0); seq_a[i] = sig_out; end
        load(8'h6B);
        for (int i = 0; i < 10; i++) begin
            drive(2'b11, 8'h00, 1'b0);
            chk(sig_out == seq_a[i], "R6", sig_out, seq_a[i]);
        end

        // R7 good signature
        load(8'h00);
        for (int i = 0; i < 20; i++) drive(2'b11, W'(i * 37 + 5), 1'b0);
        good_sig = m;
        chk(sig_out == good_sig, "R5 signature", sig_out, good_sig);
        do_check(good_sig);
        chk(pass && checked, "R7 pass", {6'b0, pass, checked}, 8'h03);
        @(negedge clk); golden = ~good_sig;
        repeat (3) @(posedge clk); #1;
        chk(pass, "R7 hold", {7'b0, pass}, 8'h01);

        // R8 single-bit error
        load(8'h00);
        for (int i = 0; i < 20; i++) begin
            wrd = W'(i * 37 + 5);
            if (i == 7) wrd = wrd ^ 8'h10;
            drive(2'b11, wrd, 1'b0);
        end
        bad_sig = sig_out;
        chk(bad_sig != good_sig, "R8 signature differs", bad_sig, good_sig);
        do_check(good_sig);
        chk(!pass && checked, "R8 pass cleared", {6'b0, pass, checked}, 8'h01);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule